// File: doc/BRIEF.md
# Write Protection Command Sequencer

This block sits beside the page write controller of a byte-alterable nonvolatile memory. It watches every byte-write strobe, with its 17-bit address and 8-bit data, for fixed command sequences. From them it produces a per-write permit signal that says whether the write may reach the array.

While protection is set, an ordinary write is refused. To write, the host first issues a three-write unlock. This opens a load window for one burst of up to 256 bytes. When the burst ends, the window closes and protection stays set. Issuing the unlock also sets protection if it was clear before.

A separate six-write disable sequence clears protection. The clear takes effect once a programmable write-cycle delay has run out. The protection flag stands for a nonvolatile bit and is modelled as a register that resets to the unprotected state.

Top module: `wp_cmd_seq`

## Requirements
- R1: After reset, `prot_o` and `open_o` are 0 and every write strobe raises `wr_permit` in the same cycle.
- R2: Three consecutive writes, data 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555, set `prot_o` and `open_o` from the clock edge that samples the third write.
- R3: While `open_o` is 1, every strobe is permitted. The window closes at the edge that samples `burst_done`, or at the edge that samples the PAGE_BYTES-th write of the burst, and `prot_o` remains 1 afterwards.
- R4: While `prot_o` is 1 and `open_o` is 0, `wr_permit` stays 0 for every write, including writes that are command steps.
- R5: The unlock sets `prot_o` even when the block was unprotected. While unprotected, command writes are themselves permitted.
- R6: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 clear `prot_o` exactly CLR_CYCLES clock edges after the edge that samples the sixth write. Writes before that edge stay blocked.
- R7: Address bits 16 and 15 are ignored when command addresses are compared.
- R8: A write that does not match the next expected step returns the sequencer to idle and is handled as an ordinary write. A later write that would have been the next step does not complete the sequence.
- R9: Writes made while the window is open never advance the command sequencer.
- R10: An unlock that completes while a disable delay is still running cancels the pending clear, so `prot_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle byte write strobe |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| burst_done | input | 1 | Page controller reports the end of the current load burst |
| wr_permit | output | 1 | Current strobe may be stored into the array |
| prot_o | output | 1 | Protection flag |
| open_o | output | 1 | Unlocked load window is open |

## Verification
The sequences are driven in several forms: a correct unlock, an unlock with the upper address bits set, a chain broken by one wrong step, and a disable chain. Together these separate exact matching and address masking from the fallback to idle. Bursts that end through `burst_done` and bursts that run to the full 256-byte limit show the two ways the window can close. A command pattern written inside an open window shows that window data is never decoded. A disable that is overtaken by an unlock, and a disable that is left to expire, pin down the clear delay and its cancellation.

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq #(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BYTES = 256,
  parameter int CLR_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              burst_done,
  output logic              wr_permit,
  output logic              prot_o,
  output logic              open_o
);
  localparam int BW = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
  localparam int DW = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1;
  localparam logic [BW-1:0] LAST_B = BW'(PAGE_BYTES - 1);
  localparam logic [DW-1:0] DLY_LD = DW'(CLR_CYCLES - 1);

  logic [2:0]    seq;
  logic [BW-1:0] bcnt;
  logic [DW-1:0] dly;
  logic          pend;
  logic          hit;

  wire at_a = wr_addr[14:0] == 15'h5555;
  wire at_b = wr_addr[14:0] == 15'h2AAA;
  wire cmd  = wr_stb && !open_o;

  always_comb begin
    case (seq)
      3'd0:    hit = at_a && wr_data == 8'hAA;
      3'd1:    hit = at_b && wr_data == 8'h55;
      3'd2:    hit = at_a && (wr_data == 8'hA0 || wr_data == 8'h80);
      3'd3:    hit = at_a && wr_data == 8'hAA;
      3'd4:    hit = at_b && wr_data == 8'h55;
      3'd5:    hit = at_a && wr_data == 8'h20;
      default: hit = 1'b0;
    endcase
  end

  wire unlock = cmd && hit && seq == 3'd2 && wr_data == 8'hA0;
  wire disarm = cmd && hit && seq == 3'd5;

  assign wr_permit = wr_stb && (open_o || !prot_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq    <= 3'd0;
      bcnt   <= '0;
      dly    <= '0;
      pend   <= 1'b0;
      prot_o <= 1'b0;
      open_o <= 1'b0;
    end else begin
      if (pend) begin
        if (dly == '0) begin
          prot_o <= 1'b0;
          pend   <= 1'b0;
        end else begin
          dly <= dly - 1'b1;
        end
      end
      if (open_o) begin
        if (burst_done || (wr_stb && bcnt == LAST_B)) begin
          open_o <= 1'b0;
          bcnt   <= '0;
        end else if (wr_stb) begin
          bcnt <= bcnt + 1'b1;
        end
      end else if (cmd) begin
        if (unlock) begin
          prot_o <= 1'b1;
          open_o <= 1'b1;
          pend   <= 1'b0;
          bcnt   <= '0;
          seq    <= 3'd0;
        end else if (disarm) begin
          pend <= 1'b1;
          dly  <= DLY_LD;
          seq  <= 3'd0;
        end else if (hit) begin
          seq <= seq + 3'd1;
        end else begin
          seq <= 3'd0;
        end
      end
    end
  end
endmodule

module wp_cmd_seq_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              burst_done,
  input logic              wr_permit,
  input logic              prot_o,
  input logic              open_o
);
  // R1
  permit_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_permit |-> wr_stb);
  // R2
  unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> $past(wr_stb && wr_data == 8'hA0 && wr_addr[14:0] == 15'h5555));
  // R3
  burst_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && burst_done) |=> !open_o);
  // R3
  window_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_o |-> prot_o);
  // R5
  prot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_o) |-> $rose(open_o));
  // R6
  prot_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_o) |-> !open_o);
endmodule

bind wp_cmd_seq wp_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_wp_cmd_seq.sv
`timescale 1ns/1ps
module sim_wp_cmd_seq;
  localparam int PB  = 256;
  localparam int CLR = 16;

  logic clk = 0, rst_n = 0;
  logic stb = 0, bdone = 0;
  logic [16:0] addr = 0;
  logic [7:0]  data = 0;
  logic permit, prot, open;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  wp_cmd_seq #(.ADDR_W(17), .PAGE_BYTES(PB), .CLR_CYCLES(CLR)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(stb), .wr_addr(addr), .wr_data(data),
    .burst_done(bdone), .wr_permit(permit), .prot_o(prot), .open_o(open));

  // behavioural reference
  int m_prot = 0, m_open = 0, m_step = 0, m_bytes = 0, m_wait = -1;
  int exp_a [6] = '{'h5555, 'h2AAA, 'h5555, 'h5555, 'h2AAA, 'h5555};
  int exp_d [6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h20};

  always @(posedge clk) begin
    if (rst_n) begin
      int a;
      a = int'(addr) % 32768;
      if (m_wait == 0) m_prot = 0;
      if (m_wait >= 0) m_wait--;
      if (m_open != 0) begin
        if (stb) m_bytes++;
        if (bdone || m_bytes == PB) begin m_open = 0; m_bytes = 0; end
      end else if (stb) begin
        if (m_step == 2 && a == 'h5555 && data == 8'hA0) begin
          m_prot = 1; m_open = 1; m_bytes = 0; m_step = 0; m_wait = -1;
        end else if (a == exp_a[m_step] && int'(data) == exp_d[m_step]) begin
          if (m_step == 5) begin m_step = 0; m_wait = CLR - 1; end
          else m_step++;
        end else m_step = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic [16:0] a, input logic [7:0] d,
                      input logic bd, input string tag);
    @(negedge clk);
    stb = s; addr = a; data = d; bdone = bd;
    #1;
    chk(tag, permit, s && (m_open != 0 || m_prot == 0), "wr_permit");
    chk(tag, prot, m_prot != 0, "prot_o");
    chk(tag, open, m_open != 0, "open_o");
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input string tag);
    step(1'b1, a, d, 1'b0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 17'h0, 8'h0, 1'b0, tag);
  endtask

  task automatic unlock(input string tag);
    wr(17'h05555, 8'hAA, tag); wr(17'h02AAA, 8'h55, tag); wr(17'h05555, 8'hA0, tag);
  endtask

  task automatic disable_seq(input string tag);
    wr(17'h05555, 8'hAA, tag); wr(17'h02AAA, 8'h55, tag); wr(17'h05555, 8'h80, tag);
    wr(17'h05555, 8'hAA, tag); wr(17'h02AAA, 8'h55, tag); wr(17'h05555, 8'h20, tag);
  endtask

  initial begin
    #(8 * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", prot, 1'b0, "reset prot_o");
    chk("R1", open, 1'b0, "reset open_o");
    rst_n = 1;
    idle(2, "R1");
    wr(17'h00123, 8'h5A, "R1");
    // broken chain, then a stray third step
    wr(17'h05555, 8'hAA, "R8"); wr(17'h02AAA, 8'h55, "R8");
    wr(17'h05555, 8'h12, "R8"); wr(17'h05555, 8'hA0, "R8");
    idle(2, "R8");
    chk("R8", prot, 1'b0, "prot after broken chain");
    // unlock from unprotected, upper address bits set
    wr(17'h1D555, 8'hAA, "R7"); wr(17'h0AAAA, 8'h55, "R7"); wr(17'h15555, 8'hA0, "R5");
    idle(1, "R2");
    chk("R2", open, 1'b1, "window after unlock");
    chk("R5", prot, 1'b1, "prot after unlock");
    // command pattern as window data
    wr(17'h05555, 8'hAA, "R9"); wr(17'h02AAA, 8'h55, "R9"); wr(17'h05555, 8'hA0, "R9");
    step(1'b0, 17'h0, 8'h0, 1'b1, "R3");
    idle(2, "R3");
    chk("R9", open, 1'b0, "window stays shut");
    // protected, no window
    wr(17'h00200, 8'h11, "R4");
    wr(17'h05555, 8'hAA, "R4");
    wr(17'h00000, 8'h33, "R4");
    idle(1, "R4");
    // full burst limit
    unlock("R2");
    for (int i = 0; i < PB; i++) wr(17'(i), 8'(i), "R3");
    wr(17'h00010, 8'h77, "R3");
    idle(1, "R3");
    chk("R3", prot, 1'b1, "prot after full burst");
    // disable overtaken by unlock
    disable_seq("R6");
    idle(4, "R10");
    unlock("R10");
    step(1'b0, 17'h0, 8'h0, 1'b1, "R10");
    idle(CLR + 4, "R10");
    chk("R10", prot, 1'b1, "prot kept");
    // disable left to expire
    disable_seq("R6");
    wr(17'h00300, 8'h44, "R6");
    idle(CLR + 2, "R6");
    chk("R6", prot, 1'b0, "prot cleared");
    wr(17'h00300, 8'h44, "R6");
    // command writes stored while unprotected, then protection set again
    unlock("R5");
    wr(17'h00400, 8'h01, "R5");
    step(1'b0, 17'h0, 8'h0, 1'b1, "R5");
    wr(17'h00400, 8'h02, "R4");
    idle(2, "R4");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule